// File: doc/BRIEF.md
# Taskfile Command Sequencer

This block sits behind the bulk-transport wrapper of a storage bridge. The wrapper hands over a vendor-specific command block. The block checks the block's length, its signature byte and its subcommand byte. When all three match, it performs a chosen set of ATA taskfile register reads or writes on a simple 8-bit register bus. Each access uses an address, a read or write strobe, and a ready handshake. A block that fails the check is flagged as not recognised, and the bus is left untouched.

A bitmap in the command block selects which of the eight taskfile registers take part. Those registers are always visited in ascending bit order. Before the first access the block can wait until the device reports not busy, by reading alternate status again and again. For a read command it builds a 12-byte response image. For a write command it supplies each register's data from the block and decides where the device-select (DEV) bit comes from. Device errors and bus phase errors are reported as flags, and each one can either stop the sequence or be overridden. A one-cycle done pulse ends every accepted command.

The wrapper presents bytes 0 to 11 of the command block, with byte n at `cmd_block[8n+7:8n]`, and the full received length on `cmd_len`. Bytes 12 to 15 carry no meaning for this block.

Top module: `tfs_sequencer`

## Requirements
- R1: A command is accepted only when it is presented while the block is not busy, `cmd_len` equals 16, byte 0 equals `cfg_sig` and byte 1 equals 0x25. For any other presented command, `cmd_unrec` pulses high for one cycle on the following cycle, no bus access takes place and no done pulse is raised.
- R2: Byte 2 is the register-select bitmap, and only registers whose bit is set are accessed. Accesses go strictly from bit 0 to bit 7. The addresses are: bit 0 alternate status 0x3F6, bit 1 features/error 0x1F1, bit 2 sector count 0x1F2, bit 3 LBA low 0x1F3, bit 4 LBA mid 0x1F4, bit 5 LBA high 0x1F5, bit 6 device/head 0x1F6, bit 7 command/status 0x1F7.
- R3: Byte 3 bit 1 selects the direction: 1 is a taskfile read, 0 is a taskfile write. In a write command, alternate status (bitmap bit 0) never receives a write strobe, even when it is selected.
- R4: `resp_image` is 12 bytes, with byte k at bits 8k+7:8k. After a read command, byte i (i = 0..7) holds the value read from register i when that register was selected, and 0x00 otherwise. Bytes 8 to 11 are always 0x00. The image is cleared whenever a command is accepted, so after a write command it reads all zero.
- R5: In a write command, register i is written with command byte 4+i.
- R6: Byte 3 bit 5 chooses the DEV source. When it is 0, the DEV bit is `cfg_dev_bit`. When it is 1, the DEV bit is bit 5 of byte 10, the device/head data. The chosen value appears on `dev_bit`, and it replaces bit 5 of the device/head write data.
- R7: When byte 3 bit 2 is 0, the block first reads 0x3F6 repeatedly until bit 7 (BSY) of the returned value is 0, and only then makes the selected accesses. When byte 3 bit 2 is 1, no polling read is made.
- R8: In a read command, a selected read of register 0 or register 7 that returns a value with bit 0 set raises `dev_err`. If byte 3 bit 4 is 0, the sequence then stops with `halted` high. If byte 3 bit 4 is 1, the sequence continues.
- R9: `phase_err` is raised in two cases: when a bus access sees no ready within TMO_CYCLES cycles (default 64), or when byte 3 bit 1 and bit 0 are both 1 (a read combined with host-to-device data). If byte 3 bit 3 is 0, the sequence stops with `halted` high. If byte 3 bit 3 is 1, it continues. In the second case no access at all is made before a halt.
- R10: `identify_flag` and `udma_flag` reflect byte 3 bit 7 and bit 6 of the last accepted command. They have no other effect.
- R11: Every accepted command ends with a one-cycle `done` pulse while the block is idle. `halted` is high at done only if an error stopped the sequence. `last_idx` holds the index of the last register that completed an access, or 0 when none did.
- R12: Only one strobe is active at a time. A strobe, together with its address, is held until the cycle in which `bus_ready` is sampled high, or until the timeout ends it.
- R13: While `rst` is high and right after it, the block is idle, both strobes are low, and `resp_image`, `done`, `halted` and both error flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command block present this cycle |
| cmd_len | input | 5 | Received command block length in bytes |
| cmd_block | input | 96 | Command bytes 0 to 11, byte n at bits 8n+7:8n |
| cfg_sig | input | 8 | Configured signature value expected in byte 0 |
| cfg_dev_bit | input | 1 | DEV bit taken from configuration storage |
| busy | output | 1 | A command is in progress |
| cmd_unrec | output | 1 | One-cycle pulse: presented block not recognised |
| bus_addr | output | 10 | Taskfile register address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| bus_ready | input | 1 | Access completes on this cycle |
| resp_image | output | 96 | 12-byte taskfile read image |
| done | output | 1 | One-cycle completion pulse |
| halted | output | 1 | Last command was stopped by an error |
| dev_err | output | 1 | Device error seen in last command |
| phase_err | output | 1 | Phase error seen in last command |
| last_idx | output | 3 | Index of last register accessed |
| dev_bit | output | 1 | Chosen DEV bit value |
| identify_flag | output | 1 | Identify-data flag of last command |
| udma_flag | output | 1 | UDMA flag of last command |

## Verification
The bench targets the alternate status register in a write command. A design that fails to skip it would show a write to 0x3F6 and one extra access. It also targets the busy poll with several busy replies, which a design could exit too early or skip entirely. Each error kind is tested with and without its override: a design that ignores an override would either run past a device error or stop on one it should tolerate. A read combined with host-to-device data must stop before any bus access. Write data for device/head is compared under both DEV sources, and the image is checked to return to zero after a write, which exposes stale bytes.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  localparam int TF_REGS = 8;
  localparam int ADDR_W = 10;
  localparam logic [7:0] SUBCMD_CODE = 8'h25;

  // byte 3 of the command block, MSB first
  typedef struct packed {
    logic identify;
    logic udma;
    logic dev_ovr;
    logic derr_ovr;
    logic perr_ovr;
    logic skip_poll;
    logic rd_mode;
    logic h2d;
  } act_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_POLL_REQ, ST_POLL_WAIT, ST_PICK, ST_REQ, ST_WAIT, ST_END
  } seq_st_t;

  function automatic logic [ADDR_W-1:0] tf_addr(input logic [2:0] idx);
    if (idx == 3'd0) return ADDR_W'(10'h3F6);
    return ADDR_W'(10'h1F0) + ADDR_W'(idx);
  endfunction

  function automatic logic [2:0] low_idx(input logic [TF_REGS-1:0] m);
    logic [2:0] r;
    r = 3'd0;
    for (int i = TF_REGS - 1; i >= 0; i--)
      if (m[i]) r = 3'(i);
    return r;
  endfunction
endpackage

// File: rtl/tfs_decode.sv
module tfs_decode import tfs_pkg::*; #(
  parameter int CMD_BYTES = 16,
  parameter int HDR_BYTES = 12,
  parameter int LEN_W = 5
) (
  input  logic [LEN_W-1:0]       cmd_len,
  input  logic [8*HDR_BYTES-1:0] cmd_block,
  input  logic [7:0]             cfg_sig,
  output logic                   recognised,
  output logic [TF_REGS-1:0]     sel,
  output act_t                   act,
  output logic [8*TF_REGS-1:0]   wbytes
);
  assign recognised = (cmd_len == LEN_W'(CMD_BYTES)) &&
                      (cmd_block[7:0] == cfg_sig) &&
                      (cmd_block[15:8] == SUBCMD_CODE);
  assign sel    = cmd_block[23:16];
  assign act    = act_t'(cmd_block[31:24]);
  assign wbytes = cmd_block[32 +: 8*TF_REGS];
endmodule

// File: rtl/tfs_bus_port.sv
module tfs_bus_port import tfs_pkg::*; #(
  parameter int TMO_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_ready,
  output logic              cpl,
  output logic              cpl_tmo,
  output logic [7:0]        cpl_data
);
  localparam int TMO_W = $clog2(TMO_CYCLES + 1);
  logic [TMO_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
      cpl       <= 1'b0;
      cpl_tmo   <= 1'b0;
      cpl_data  <= '0;
      wait_cnt  <= '0;
    end else begin
      cpl     <= 1'b0;
      cpl_tmo <= 1'b0;
      if (bus_rd || bus_wr) begin
        if (bus_ready) begin
          bus_rd   <= 1'b0;
          bus_wr   <= 1'b0;
          cpl      <= 1'b1;
          cpl_data <= bus_rdata;
          wait_cnt <= '0;
        end else if (wait_cnt == TMO_W'(TMO_CYCLES - 1)) begin
          bus_rd   <= 1'b0;
          bus_wr   <= 1'b0;
          cpl      <= 1'b1;
          cpl_tmo  <= 1'b1;
          cpl_data <= '0;
          wait_cnt <= '0;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
      end else if (req) begin
        bus_addr  <= req_addr;
        bus_wdata <= req_wdata;
        bus_rd    <= !req_wr;
        bus_wr    <= req_wr;
      end
    end
  end
endmodule

// File: rtl/tfs_resp_image.sv
module tfs_resp_image #(
  parameter int N_BYTES = 12,
  parameter int IDX_W = $clog2(N_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  logic [7:0]           wdata,
  output logic [8*N_BYTES-1:0] image
);
  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst || clr)
        image[8*b +: 8] <= 8'h00;
      else if (we && (widx == IDX_W'(b)))
        image[8*b +: 8] <= wdata;
    end
  end
endmodule

// File: rtl/tfs_sequencer.sv
module tfs_sequencer import tfs_pkg::*; #(
  parameter int CMD_BYTES = 16,
  parameter int HDR_BYTES = 12,
  parameter int LEN_W = 5,
  parameter int RESP_BYTES = 12,
  parameter int TMO_CYCLES = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_valid,
  input  logic [LEN_W-1:0]        cmd_len,
  input  logic [8*HDR_BYTES-1:0]  cmd_block,
  input  logic [7:0]              cfg_sig,
  input  logic                    cfg_dev_bit,
  output logic                    busy,
  output logic                    cmd_unrec,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic                    bus_rd,
  output logic                    bus_wr,
  output logic [7:0]              bus_wdata,
  input  logic [7:0]              bus_rdata,
  input  logic                    bus_ready,
  output logic [8*RESP_BYTES-1:0] resp_image,
  output logic                    done,
  output logic                    halted,
  output logic                    dev_err,
  output logic                    phase_err,
  output logic [2:0]              last_idx,
  output logic                    dev_bit,
  output logic                    identify_flag,
  output logic                    udma_flag
);
  localparam int IMG_IDX_W = $clog2(RESP_BYTES);
  localparam int DEVHEAD = 6;

  logic                   dec_ok;
  logic [TF_REGS-1:0]     dec_sel;
  act_t                   dec_act;
  logic [8*TF_REGS-1:0]   dec_wb;

  seq_st_t                state;
  logic [TF_REGS-1:0]     pend;
  act_t                   act_q;
  logic [8*TF_REGS-1:0]   wb_q;
  logic                   cfg_dev_q;
  logic [2:0]             idx_q;

  logic                   req, req_wr;
  logic [ADDR_W-1:0]      req_addr;
  logic [7:0]             req_wdata;
  logic                   cpl, cpl_tmo;
  logic [7:0]             cpl_data;
  logic                   accept, img_we;

  tfs_decode #(.CMD_BYTES(CMD_BYTES), .HDR_BYTES(HDR_BYTES), .LEN_W(LEN_W)) u_dec (
    .cmd_len(cmd_len), .cmd_block(cmd_block), .cfg_sig(cfg_sig),
    .recognised(dec_ok), .sel(dec_sel), .act(dec_act), .wbytes(dec_wb)
  );

  assign accept        = (state == ST_IDLE) && cmd_valid && dec_ok;
  assign busy          = (state != ST_IDLE);
  assign identify_flag = act_q.identify;
  assign udma_flag     = act_q.udma;
  assign dev_bit       = act_q.dev_ovr ? wb_q[8*DEVHEAD + 5] : cfg_dev_q;

  // bus request side
  assign req      = (state == ST_POLL_REQ) || (state == ST_REQ);
  assign req_wr   = (state == ST_REQ) && !act_q.rd_mode;
  assign req_addr = (state == ST_POLL_REQ) ? tf_addr(3'd0) : tf_addr(idx_q);
  always_comb begin
    req_wdata = wb_q[{idx_q, 3'b000} +: 8];
    if (idx_q == 3'(DEVHEAD)) req_wdata[5] = dev_bit;
  end

  tfs_bus_port #(.TMO_CYCLES(TMO_CYCLES)) u_port (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .cpl(cpl), .cpl_tmo(cpl_tmo), .cpl_data(cpl_data)
  );

  assign img_we = (state == ST_WAIT) && cpl && !cpl_tmo && act_q.rd_mode;

  tfs_resp_image #(.N_BYTES(RESP_BYTES), .IDX_W(IMG_IDX_W)) u_img (
    .clk(clk), .rst(rst), .clr(accept), .we(img_we),
    .widx(IMG_IDX_W'(idx_q)), .wdata(cpl_data), .image(resp_image)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= '0;
      act_q     <= '0;
      wb_q      <= '0;
      cfg_dev_q <= 1'b0;
      idx_q     <= '0;
      cmd_unrec <= 1'b0;
      done      <= 1'b0;
      halted    <= 1'b0;
      dev_err   <= 1'b0;
      phase_err <= 1'b0;
      last_idx  <= '0;
    end else begin
      cmd_unrec <= 1'b0;
      done      <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (dec_ok) begin
              pend      <= dec_sel;
              act_q     <= dec_act;
              wb_q      <= dec_wb;
              cfg_dev_q <= cfg_dev_bit;
              halted    <= 1'b0;
              dev_err   <= 1'b0;
              phase_err <= 1'b0;
              last_idx  <= '0;
              state     <= ST_START;
            end else begin
              cmd_unrec <= 1'b1;
            end
          end
        end
        ST_START: begin
          if (act_q.rd_mode && act_q.h2d) begin
            phase_err <= 1'b1;
            if (!act_q.perr_ovr) begin
              halted <= 1'b1;
              state  <= ST_END;
            end else begin
              state <= act_q.skip_poll ? ST_PICK : ST_POLL_REQ;
            end
          end else begin
            state <= act_q.skip_poll ? ST_PICK : ST_POLL_REQ;
          end
        end
        ST_POLL_REQ: state <= ST_POLL_WAIT;
        ST_POLL_WAIT: begin
          if (cpl) begin
            if (cpl_tmo) begin
              phase_err <= 1'b1;
              if (!act_q.perr_ovr) begin
                halted <= 1'b1;
                state  <= ST_END;
              end else begin
                state <= ST_PICK;
              end
            end else if (cpl_data[7]) begin
              state <= ST_POLL_REQ;
            end else begin
              state <= ST_PICK;
            end
          end
        end
        ST_PICK: begin
          if (pend == '0) begin
            state <= ST_END;
          end else if (!act_q.rd_mode && (low_idx(pend) == 3'd0)) begin
            pend[0] <= 1'b0;
          end else begin
            idx_q <= low_idx(pend);
            state <= ST_REQ;
          end
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: begin
          if (cpl) begin
            pend[idx_q] <= 1'b0;
            last_idx    <= idx_q;
            state       <= ST_PICK;
            if (cpl_tmo) begin
              phase_err <= 1'b1;
              if (!act_q.perr_ovr) begin
                halted <= 1'b1;
                state  <= ST_END;
              end
            end else if (act_q.rd_mode && ((idx_q == 3'd0) || (idx_q == 3'd7)) && cpl_data[0]) begin
              dev_err <= 1'b1;
              if (!act_q.derr_ovr) begin
                halted <= 1'b1;
                state  <= ST_END;
              end
            end
          end
        end
        ST_END: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tfs_sequencer_chk.sv
module tfs_sequencer_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              halted,
  input logic              dev_err,
  input logic              phase_err,
  input logic              cmd_unrec,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr
);
  // R12
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && !bus_ready) |=> $stable(bus_addr));
  // R12
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> busy);
  // R3
  no_altstat_write_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> (bus_addr != ADDR_W'(10'h3F6)));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R11
  halt_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (done && halted) |-> (dev_err || phase_err));
  // R1
  unrec_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_unrec |-> (!busy && !done));
endmodule

bind tfs_sequencer tfs_sequencer_chk #(.ADDR_W(10)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .halted(halted),
  .dev_err(dev_err), .phase_err(phase_err), .cmd_unrec(cmd_unrec),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ready(bus_ready), .bus_addr(bus_addr)
);

// File: tb/tfs_sequencer_test.sv
module tfs_sequencer_test;
  localparam logic [7:0] SIG = 8'h5A;
  localparam logic [63:0] WB_DEF = 64'h8877665544332211;

  typedef struct packed {
    logic [7:0] sel;
    logic [7:0] act;
    logic [7:0] n;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{sel: 8'hFF, act: 8'h06, n: 8'd8},
    '{sel: 8'hA5, act: 8'h06, n: 8'd4},
    '{sel: 8'h00, act: 8'h06, n: 8'd0},
    '{sel: 8'hFF, act: 8'h04, n: 8'd7},
    '{sel: 8'h41, act: 8'h04, n: 8'd1},
    '{sel: 8'h81, act: 8'h02, n: 8'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [4:0] cmd_len = 5'd16;
  logic [95:0] cmd_block = '0;
  logic [7:0] cfg_sig = SIG;
  logic cfg_dev_bit = 1'b0;
  logic busy, cmd_unrec, bus_rd, bus_wr, done, halted, dev_err, phase_err;
  logic dev_bit, identify_flag, udma_flag;
  logic [9:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata = 8'h00;
  logic bus_ready = 1'b0;
  logic [95:0] resp_image;
  logic [2:0] last_idx;

  int nchk = 0;
  int nfail = 0;

  // device model
  logic [7:0] stat_val = 8'h50;
  int lat = 0;
  bit never_rdy = 1'b0;
  int wcnt = 0;
  int busy_n = 0;
  int polls_done = 0;
  int polls_base = 0;
  int log_n = 0;
  int log_base = 0;
  int proto_bad = 0;
  logic [9:0] log_addr [256];
  logic       log_wr [256];
  logic [7:0] log_data [256];
  logic held_prev = 1'b0;
  logic [9:0] prev_addr = '0;

  always #10 clk = ~clk;

  tfs_sequencer uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_len(cmd_len), .cmd_block(cmd_block),
    .cfg_sig(cfg_sig), .cfg_dev_bit(cfg_dev_bit), .busy(busy), .cmd_unrec(cmd_unrec),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .resp_image(resp_image), .done(done),
    .halted(halted), .dev_err(dev_err), .phase_err(phase_err), .last_idx(last_idx),
    .dev_bit(dev_bit), .identify_flag(identify_flag), .udma_flag(udma_flag)
  );

  function automatic logic [7:0] model_val(input logic [9:0] a);
    if (a == 10'h3F6 || a == 10'h1F7)
      return ((polls_done - polls_base) < busy_n) ? 8'h80 : stat_val;
    return 8'hA0 + 8'(a - 10'h1F0);
  endfunction

  always @(negedge clk) begin
    if (bus_rd || bus_wr) begin
      bus_ready <= !never_rdy && (wcnt >= lat);
      wcnt <= wcnt + 1;
    end else begin
      bus_ready <= 1'b0;
      wcnt <= 0;
    end
    bus_rdata <= model_val(bus_addr);
  end

  always @(posedge clk) begin
    if (bus_rd && bus_wr) proto_bad <= proto_bad + 1;
    if (held_prev && (bus_rd || bus_wr) && bus_addr != prev_addr) proto_bad <= proto_bad + 1;
    held_prev <= (bus_rd || bus_wr) && !bus_ready;
    prev_addr <= bus_addr;
    if ((bus_rd || bus_wr) && bus_ready) begin
      log_addr[log_n % 256] <= bus_addr;
      log_wr[log_n % 256]   <= bus_wr;
      log_data[log_n % 256] <= bus_wr ? bus_wdata : bus_rdata;
      log_n <= log_n + 1;
      if (bus_addr == 10'h3F6) polls_done <= polls_done + 1;
    end
  end

  task automatic chk(input string tag, input logic [95:0] actual, input logic [95:0] expected);
    nchk++;
    if (actual !== expected) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  function automatic logic [95:0] exp_img(input logic [7:0] sel, input logic rd);
    logic [95:0] img;
    img = '0;
    for (int i = 0; i < 8; i++)
      if (rd && sel[i]) img[8*i +: 8] = (i == 0 || i == 7) ? stat_val : 8'hA0 + 8'(i);
    return img;
  endfunction

  logic got_unrec;
  logic got_done;

  task automatic send(input logic [4:0] len, input logic [7:0] sig, input logic [7:0] sub,
                      input logic [7:0] sel, input logic [7:0] act, input logic [63:0] wb,
                      input bit expect_acc);
    @(negedge clk);
    log_base = log_n;
    polls_base = polls_done;
    cmd_len = len;
    cmd_block = {wb, act, sel, sub, sig};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    got_unrec = cmd_unrec;
    got_done = 1'b0;
    if (expect_acc) begin
      for (int k = 0; k < 3000; k++) begin
        if (done) begin
          got_done = 1'b1;
          break;
        end
        @(negedge clk);
      end
    end else begin
      for (int k = 0; k < 8; k++) begin
        if (done) got_done = 1'b1;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R13 reset state
    chk("R13 busy", 96'(busy), 96'd0);
    chk("R13 strobes", 96'({bus_rd, bus_wr}), 96'd0);
    chk("R13 image/flags", 96'(resp_image) | 96'({done, halted, dev_err, phase_err}), 96'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 after reset", 96'({busy, done, halted, bus_rd, bus_wr}), 96'd0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic rd;
      logic [7:0] eff;
      int ne;
      int bad;
      int top;
      int walls;
      logic devv;
      logic [7:0] ed;
      lat = v % 3;
      rd = VEC[v].act[1];
      eff = rd ? VEC[v].sel : (VEC[v].sel & 8'hFE);
      send(5'd16, SIG, 8'h25, VEC[v].sel, VEC[v].act, WB_DEF, 1'b1);
      chk($sformatf("R11 done vec%0d", v), 96'(got_done), 96'd1);
      chk($sformatf("R2 count vec%0d", v), 96'(log_n - log_base), 96'(VEC[v].n));
      ne = 0;
      bad = 0;
      top = 0;
      walls = 0;
      devv = VEC[v].act[5] ? WB_DEF[53] : cfg_dev_bit;
      for (int i = 0; i < 8; i++) if (eff[i]) ne++;
      for (int i = 0, j = log_n - ne; i < 8; i++) begin
        if (eff[i]) begin
          top = i;
          if (log_addr[j % 256] != ((i == 0) ? 10'h3F6 : 10'h1F0 + 10'(i))) bad++;
          if (!rd) begin
            ed = WB_DEF[8*i +: 8];
            if (i == 6) ed[5] = devv;
            if (log_data[j % 256] != ed || !log_wr[j % 256]) bad++;
          end
          j++;
        end
      end
      for (int j = log_base; j < log_n; j++)
        if (log_wr[j % 256] && log_addr[j % 256] == 10'h3F6) walls++;
      chk($sformatf("R2 order vec%0d", v), 96'(bad), 96'd0);
      if (!rd) begin
        chk($sformatf("R5 write data vec%0d", v), 96'(bad), 96'd0);
        chk($sformatf("R3 alt write vec%0d", v), 96'(walls), 96'd0);
      end
      chk($sformatf("R4 image vec%0d", v), resp_image, exp_img(VEC[v].sel, rd));
      chk($sformatf("R11 halted vec%0d", v), 96'({halted, dev_err, phase_err}), 96'd0);
      chk($sformatf("R11 last_idx vec%0d", v), 96'(last_idx), 96'(top));
    end
    lat = 1;

    // R1 unrecognised blocks
    send(5'd15, SIG, 8'h25, 8'hFF, 8'h06, WB_DEF, 1'b0);
    chk("R1 short length unrec", 96'({got_unrec, got_done, 8'(log_n - log_base)}), 96'h200);
    send(5'd16, 8'h5B, 8'h25, 8'hFF, 8'h06, WB_DEF, 1'b0);
    chk("R1 bad signature unrec", 96'({got_unrec, got_done, 8'(log_n - log_base)}), 96'h200);
    send(5'd16, SIG, 8'h24, 8'hFF, 8'h06, WB_DEF, 1'b0);
    chk("R1 bad subcmd unrec", 96'({got_unrec, got_done, 8'(log_n - log_base)}), 96'h200);

    // R7 busy polling
    busy_n = 3;
    send(5'd16, SIG, 8'h25, 8'h04, 8'h02, WB_DEF, 1'b1);
    chk("R7 poll count", 96'(log_n - log_base), 96'd5);
    chk("R7 poll addrs", 96'({log_addr[log_base % 256], log_addr[(log_base + 3) % 256], log_addr[(log_base + 4) % 256]}),
        96'({10'h3F6, 10'h3F6, 10'h1F2}));
    busy_n = 0;
    send(5'd16, SIG, 8'h25, 8'h04, 8'h06, WB_DEF, 1'b1);
    chk("R7 skip poll", 96'({log_n - log_base == 1, log_addr[log_base % 256]}), 96'({1'b1, 10'h1F2}));

    // R6 DEV source
    cfg_dev_bit = 1'b1;
    send(5'd16, SIG, 8'h25, 8'h40, 8'h04, 64'h00_1F_00_00_00_00_00_00, 1'b1);
    chk("R6 DEV from config", 96'({dev_bit, log_data[log_base % 256]}), 96'h13F);
    send(5'd16, SIG, 8'h25, 8'h40, 8'h24, 64'h00_1F_00_00_00_00_00_00, 1'b1);
    chk("R6 DEV from block", 96'({dev_bit, log_data[log_base % 256]}), 96'h01F);
    chk("R4 image zero after write", resp_image, 96'd0);
    cfg_dev_bit = 1'b0;

    // R8 device error
    stat_val = 8'h51;
    send(5'd16, SIG, 8'h25, 8'h81, 8'h06, WB_DEF, 1'b1);
    chk("R8 dev error halts", 96'({dev_err, halted, last_idx, 8'(log_n - log_base)}), 96'h1801);
    send(5'd16, SIG, 8'h25, 8'h81, 8'h16, WB_DEF, 1'b1);
    chk("R8 dev error override", 96'({dev_err, halted, last_idx, 8'(log_n - log_base)}), 96'h1702);
    stat_val = 8'h50;

    // R9 phase errors
    never_rdy = 1'b1;
    send(5'd16, SIG, 8'h25, 8'h06, 8'h06, WB_DEF, 1'b1);
    chk("R9 timeout halts", 96'({phase_err, halted, last_idx, 8'(log_n - log_base)}), 96'h1900);
    send(5'd16, SIG, 8'h25, 8'h06, 8'h0E, WB_DEF, 1'b1);
    chk("R9 timeout override", 96'({phase_err, halted, last_idx, got_done}), 96'h25);
    never_rdy = 1'b0;
    send(5'd16, SIG, 8'h25, 8'h02, 8'h07, WB_DEF, 1'b1);
    chk("R9 read with h2d halts", 96'({phase_err, halted, 8'(log_n - log_base)}), 96'h300);
    send(5'd16, SIG, 8'h25, 8'h02, 8'h0F, WB_DEF, 1'b1);
    chk("R9 read with h2d override", 96'({phase_err, halted, 8'(log_n - log_base)}), 96'h201);

    // R10 flags
    send(5'd16, SIG, 8'h25, 8'h00, 8'hC6, WB_DEF, 1'b1);
    chk("R10 flags set", 96'({identify_flag, udma_flag, 8'(log_n - log_base)}), 96'h300);
    send(5'd16, SIG, 8'h25, 8'h00, 8'h06, WB_DEF, 1'b1);
    chk("R10 flags clear", 96'({identify_flag, udma_flag}), 96'd0);

    // R12 bus protocol over the whole run
    chk("R12 protocol violations", 96'(proto_bad), 96'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule